// File: doc/BRIEF.md
# Device-Side DMA Handshake Controller

This block is the device end of a request/acknowledge DMA link for a USB device controller. An external single-channel DMA engine of the classic 8237 kind drives an acknowledge line, read and write strobes and an end-of-transfer line. The block answers with a request line. A configuration register picks one of sixteen endpoint slots as the DMA target. Slots 2 to 15 carry data endpoints 1 to 14, and slots 0 and 1 switch DMA off. Each slot has a direction bit that fixes which way the data flows, so the transfer direction is never programmed on its own.

While acknowledge is active, every strobe goes to the DMA slot, whatever slot the CPU I/O path has selected. At other times the strobes pass straight through to the CPU slot. The endpoint buffers stay outside the block. Each one shows a fill level and a short-packet flag, and the block reports which slot a strobe addresses. The request line is raised when the target slot can move a byte. It is dropped after a programmable burst of 1, 4, 8 or 16 strobes. A sticky done flag stops the transfer on an end-of-transfer pulse, on the programmed byte count, on the last byte of a short packet, or on an empty packet.

Top module: `dma_handshake`

## Requirements
- R1: A synchronous active-low reset clears all configuration, the byte and beat counts and the done flag. After reset `dreq_pin` is low and `buf_sel` follows `io_ep_sel`.
- R2: Bit n of the direction register (address 1) gives slot n's type. 0 means OUT, where the DMA reads: an acknowledged `rd_stb` pulses `buf_rd` and an acknowledged `wr_stb` is ignored. 1 means IN, where the DMA writes: an acknowledged `wr_stb` pulses `buf_wr` and an acknowledged `rd_stb` is ignored. `bus_dout` carries `buf_rdata` and `buf_wdata` carries `bus_din`.
- R3: While acknowledge is active, `buf_sel` equals the DMA slot index (address 0 bits 3:0). Otherwise it equals `io_ep_sel`.
- R4: With a DMA slot index of 2 or more and no done flag, the request becomes active one clock after the slot is ready. An OUT slot is ready when its fill is nonzero. An IN slot is ready when its fill is below FIFO_DEPTH. An index of 0 or 1 keeps the request inactive.
- R5: Address 0 bits 5:4 set the burst length: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 16. The request goes inactive in the clock after the strobe that completes a burst. It is re-raised one clock later if the slot is still ready.
- R6: An `eot_in` that is high during a DMA strobe lets that byte complete, sets the done flag and drops the request.
- R7: When the byte-count register (address 2) is nonzero, the DMA strobe that reaches that count sets the done flag. The count restarts on every write to address 0 and on every done clear.
- R8: On an OUT slot with its short flag set, reading the byte at fill 1 sets the done flag. A short flag with fill 0 (an empty packet) sets the done flag with no strobe.
- R9: The done flag stays set and holds the request inactive until a write to address 3 with bit 0 set clears it. A set condition in the same clock wins over the clear.
- R10: Address 0 bit 6 makes `dreq_pin` active low. Address 0 bit 7 makes `dack_pin` active low.
- R11: With address 0 bit 8 clear, the acknowledge line moves data only together with a strobe. With bit 8 set, every clock in which acknowledge is active moves one byte without any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| io_ep_sel | input | 4 | Slot selected by the CPU I/O path |
| dack_pin | input | 1 | DMA acknowledge, programmable polarity |
| rd_stb | input | 1 | Read strobe, one byte per high clock |
| wr_stb | input | 1 | Write strobe, one byte per high clock |
| eot_in | input | 1 | End of transfer from the DMA engine, active high |
| bus_din | input | 8 | Data from the bus |
| bus_dout | output | 8 | Data to the bus |
| dreq_pin | output | 1 | DMA request, programmable polarity |
| dma_done | output | 1 | Sticky transfer-finished flag |
| buf_sel | output | 4 | Slot addressed by the current access |
| buf_rd | output | 1 | Pop one byte from the addressed slot |
| buf_wr | output | 1 | Push one byte into the addressed slot |
| buf_wdata | output | 8 | Byte pushed into the slot |
| buf_rdata | input | 8 | Byte at the head of the addressed slot |
| buf_fill | input | NUM_EP*LVL_W | Fill level of every slot, slot n at bits n*LVL_W |
| buf_short | input | 16 | Short-packet flag for every slot |

## Verification
The hardest cases to reach are those where the done flag, the burst boundary and the request logic act in the same clock. One is a short packet whose last byte arrives in the middle of a burst. Another is an empty packet that shows up right after a clear. A third is a polarity change made while the acknowledge line is at a level that would suddenly count as active. The bench owns a behavioural model of the endpoint buffers. It rewrites the fill levels and short flags between steps, so it can set up a three-byte short packet under a 16-byte burst, or a zero fill with the short flag set. Before every polarity or mode write it moves the acknowledge line to its new inactive level. It compares a reference model on every clock, so the cycles on both sides of each boundary are checked as well.

// File: rtl/dma_hs_pkg.sv
// Shared types for the DMA handshake controller.
// Assumes a 4-bit slot index, so sixteen slots, and a 16-bit register write port.
package dma_hs_pkg;
    localparam int IDX_W  = 4;
    localparam int NUM_EP = 1 << IDX_W;
    localparam int REG_W  = 16;

    typedef enum logic [1:0] {
        A_CFG = 2'd0,
        A_DIR = 2'd1,
        A_CNT = 2'd2,
        A_CLR = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             dack_only;
        logic             dack_low;
        logic             dreq_low;
        logic [1:0]       burst;
        logic [IDX_W-1:0] idx;
    } dma_cfg_t;

    // Burst code to strobes per request: 1, 4, 8, 16
    function automatic logic [4:0] burst_len(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/dma_hs_cfg.sv
// Register file for the DMA handshake controller.
// Holds the configuration word, the per-slot direction mask and the byte-count limit.
// Emits one-clock pulses for a done clear and for a configuration rewrite.
// Assumes CNT_W <= 16.
module dma_hs_cfg
    import dma_hs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [REG_W-1:0]    wdata,
    output dma_cfg_t            cfg,
    output logic [NUM_EP-1:0]   dir_mask,
    output logic [CNT_W-1:0]    xfer_len,
    output logic                clr_done,
    output logic                restart
);
    // Register writes, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            dir_mask <= '0;
            xfer_len <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CFG:   cfg      <= dma_cfg_t'(wdata[$bits(dma_cfg_t)-1:0]);
                A_DIR:   dir_mask <= wdata[NUM_EP-1:0];
                A_CNT:   xfer_len <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Command pulses decoded from the current write
    always_comb begin
        clr_done = wr_en && (reg_addr_e'(addr) == A_CLR) && wdata[0];
        restart  = wr_en && (reg_addr_e'(addr) == A_CFG);
    end
endmodule

// File: rtl/dma_hs_route.sv
// Access router: decides whether the acknowledge line is active, then steers
// strobes to the DMA slot or to the CPU slot. Direction comes from the slot's mask bit.
// Also picks the target slot's fill level and short flag.
module dma_hs_route
    import dma_hs_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic [IDX_W-1:0]        dma_idx,
    input  logic                    dack_low,
    input  logic                    dack_only,
    input  logic [NUM_EP-1:0]       dir_mask,
    input  logic [IDX_W-1:0]        io_sel,
    input  logic                    dack_pin,
    input  logic                    rd,
    input  logic                    wr,
    input  logic [NUM_EP*LVL_W-1:0] fill_flat,
    input  logic [NUM_EP-1:0]       short_flags,
    output logic                    dma_act,
    output logic                    dma_stb,
    output logic                    ep_in,
    output logic [LVL_W-1:0]        ep_fill,
    output logic                    ep_short,
    output logic [IDX_W-1:0]        buf_sel,
    output logic                    buf_rd,
    output logic                    buf_wr
);
    logic [LVL_W-1:0] fill_arr [NUM_EP];

    // Unpack the flat fill bus into one level per slot
    for (genvar g = 0; g < NUM_EP; g++) begin : g_unpack
        assign fill_arr[g] = fill_flat[g*LVL_W +: LVL_W];
    end

    // Acknowledge decode, target slot status and strobe steering
    always_comb begin
        dma_act  = (dack_pin != dack_low);
        ep_in    = dir_mask[dma_idx];
        ep_fill  = fill_arr[dma_idx];
        ep_short = short_flags[dma_idx];
        dma_stb  = dma_act && (dack_only || (ep_in ? wr : rd));
        buf_sel  = dma_act ? dma_idx : io_sel;
        buf_rd   = dma_act ? (dma_stb && !ep_in) : rd;
        buf_wr   = dma_act ? (dma_stb && ep_in) : wr;
    end
endmodule

// File: rtl/dma_hs_ctrl.sv
// Request sequencer: raises the request when the target slot is ready and counts
// burst beats and transferred bytes. Sets the sticky done flag on end of transfer,
// on the byte-count limit, on a short packet or on an empty packet.
// Assumes the fill level is valid in the same clock as the strobe.
module dma_hs_ctrl
    import dma_hs_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = 7,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       burst,
    input  logic             ep_in,
    input  logic [LVL_W-1:0] ep_fill,
    input  logic             ep_short,
    input  logic             dma_stb,
    input  logic             eot,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             clr_done,
    input  logic             restart,
    output logic             dreq_lvl,
    output logic             done,
    output logic [3:0]       beats
);
    logic [CNT_W-1:0] bytes;
    logic [4:0]       blen;
    logic             ready, last_beat, hit_count, short_end, empty_end, finish;

    // Terminal conditions and readiness of the target slot
    always_comb begin
        blen      = burst_len(burst);
        ready     = ep_in ? (ep_fill < LVL_W'(FIFO_DEPTH)) : (ep_fill != '0);
        last_beat = dma_stb && ((5'(beats) + 5'd1) == blen);
        hit_count = dma_stb && (xfer_len != '0) && ((bytes + CNT_W'(1)) == xfer_len);
        short_end = dma_stb && !ep_in && ep_short && (ep_fill == LVL_W'(1));
        empty_end = en && !ep_in && ep_short && (ep_fill == '0);
        finish    = (dma_stb && (eot || hit_count || short_end)) || empty_end;
    end

    // Sticky done flag; a set in the same clock wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (finish)   done <= 1'b1;
        else if (clr_done) done <= 1'b0;
    end

    // Bytes moved since the last restart or clear
    always_ff @(posedge clk) begin
        if (!rst_n || restart || clr_done) bytes <= '0;
        else if (dma_stb)                  bytes <= bytes + CNT_W'(1);
    end

    // Beats within the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || restart || finish) beats <= '0;
        else if (dma_stb)                beats <= last_beat ? 4'd0 : beats + 4'd1;
    end

    // Request level: dropped on end or burst boundary, raised when ready
    always_ff @(posedge clk) begin
        if (!rst_n || !en || done || finish) dreq_lvl <= 1'b0;
        else if (last_beat)                  dreq_lvl <= 1'b0;
        else if (!dreq_lvl && ready)         dreq_lvl <= 1'b1;
    end
endmodule

// File: rtl/dma_handshake.sv
// Top of the device-side DMA handshake controller.
// Joins the register file, the access router and the request sequencer.
// Applies the request polarity and passes the data straight through.
// Assumes endpoint buffers outside the block that act on buf_rd and buf_wr each clock.
module dma_handshake
    import dma_hs_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [1:0]              cfg_addr,
    input  logic [15:0]             cfg_wdata,
    input  logic [3:0]              io_ep_sel,
    input  logic                    dack_pin,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic                    eot_in,
    input  logic [DATA_W-1:0]       bus_din,
    output logic [DATA_W-1:0]       bus_dout,
    output logic                    dreq_pin,
    output logic                    dma_done,
    output logic [3:0]              buf_sel,
    output logic                    buf_rd,
    output logic                    buf_wr,
    output logic [DATA_W-1:0]       buf_wdata,
    input  logic [DATA_W-1:0]       buf_rdata,
    input  logic [16*LVL_W-1:0]     buf_fill,
    input  logic [15:0]             buf_short
);
    dma_cfg_t          cfg;
    logic [NUM_EP-1:0] dir_mask;
    logic [CNT_W-1:0]  xfer_len;
    logic              clr_done, restart;
    logic              dma_act, dma_stb, ep_in, ep_short, dreq_lvl;
    logic [LVL_W-1:0]  ep_fill;
    logic [3:0]        beats;

    dma_hs_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .dir_mask(dir_mask), .xfer_len(xfer_len),
        .clr_done(clr_done), .restart(restart)
    );

    dma_hs_route #(.LVL_W(LVL_W)) u_route (
        .dma_idx(cfg.idx), .dack_low(cfg.dack_low), .dack_only(cfg.dack_only),
        .dir_mask(dir_mask), .io_sel(io_ep_sel), .dack_pin(dack_pin),
        .rd(rd_stb), .wr(wr_stb), .fill_flat(buf_fill), .short_flags(buf_short),
        .dma_act(dma_act), .dma_stb(dma_stb), .ep_in(ep_in), .ep_fill(ep_fill),
        .ep_short(ep_short), .buf_sel(buf_sel), .buf_rd(buf_rd), .buf_wr(buf_wr)
    );

    dma_hs_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(cfg.idx >= 4'd2), .burst(cfg.burst),
        .ep_in(ep_in), .ep_fill(ep_fill), .ep_short(ep_short), .dma_stb(dma_stb),
        .eot(eot_in), .xfer_len(xfer_len), .clr_done(clr_done), .restart(restart),
        .dreq_lvl(dreq_lvl), .done(dma_done), .beats(beats)
    );

    // Pin polarity and data pass-through
    always_comb begin
        dreq_pin  = dreq_lvl ^ cfg.dreq_low;
        bus_dout  = buf_rdata;
        buf_wdata = bus_din;
    end
endmodule

// File: rtl/dma_handshake_chk.sv
// Property checker for dma_handshake, attached with bind below.
// Assumes the internal signal names of the top module.
module dma_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dma_act,
    input logic       dma_stb,
    input logic       ep_in,
    input logic       eot_in,
    input logic       done,
    input logic       clr_done,
    input logic       dreq_lvl,
    input logic [3:0] idx,
    input logic [1:0] burst,
    input logic [3:0] beats,
    input logic       buf_wr
);
    AST_OUT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_act && !ep_in) |-> !buf_wr); // R2
    AST_IDX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idx < 4'd2) |=> !dreq_lvl); // R4
    AST_BEATS_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (5'(beats) < dma_hs_pkg::burst_len(burst))); // R5
    AST_EOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_stb && eot_in) |=> done); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !dreq_lvl); // R9
endmodule

bind dma_handshake dma_handshake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dma_act(dma_act), .dma_stb(dma_stb), .ep_in(ep_in),
    .eot_in(eot_in), .done(dma_done), .clr_done(clr_done), .dreq_lvl(dreq_lvl),
    .idx(cfg.idx), .burst(cfg.burst), .beats(beats), .buf_wr(buf_wr)
);

// File: tb/dma_handshake_test.sv
// Bench for dma_handshake: behavioural reference model plus endpoint buffer model,
// compared every clock, with directed scenarios and explicit checks.
module dma_handshake_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int LVL_W      = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0] io_ep_sel = '0;
    logic dack_pin = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, eot_in = 1'b0;
    logic [7:0] bus_din = '0, buf_rdata = '0;
    logic [7:0] bus_dout, buf_wdata;
    logic dreq_pin, dma_done, buf_rd, buf_wr;
    logic [3:0] buf_sel;
    logic [16*LVL_W-1:0] buf_fill;
    logic [15:0] buf_short = '0;

    int fill [16];
    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model state
    int m_idx, m_burst, m_cnt, m_beats, m_bytes;
    bit m_dreq_low, m_dack_low, m_donly, m_dreq, m_done;
    bit [15:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int g = 0; g < 16; g++) buf_fill[g*LVL_W +: LVL_W] = LVL_W'(fill[g]);
    end

    dma_handshake uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .io_ep_sel(io_ep_sel), .dack_pin(dack_pin), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .eot_in(eot_in), .bus_din(bus_din), .bus_dout(bus_dout), .dreq_pin(dreq_pin),
        .dma_done(dma_done), .buf_sel(buf_sel), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .buf_fill(buf_fill), .buf_short(buf_short)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int blen_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    // One clock: compare routing before the edge, update models, compare registers after
    task automatic tick();
        bit act, dir, stb, brd, bwr, en, ready, last, fin, clr, rs;
        int sel;
        #1;
        act = (dack_pin == !m_dack_low);
        dir = m_mask[m_idx];
        stb = act && (m_donly || (dir ? wr_stb : rd_stb));
        sel = act ? m_idx : int'(io_ep_sel);
        brd = act ? (stb && !dir) : rd_stb;
        bwr = act ? (stb && dir) : wr_stb;
        check(int'(buf_sel) == sel, "R3 buf_sel", buf_sel, sel);
        check(buf_rd == brd && buf_wr == bwr, "R2 strobes", {buf_rd, buf_wr}, {brd, bwr});
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_idx = 0; m_burst = 0; m_cnt = 0; m_beats = 0; m_bytes = 0; m_mask = '0;
            m_dreq_low = 0; m_dack_low = 0; m_donly = 0; m_dreq = 0; m_done = 0;
        end else begin
            en    = m_idx >= 2;
            ready = dir ? (fill[m_idx] < DEPTH) : (fill[m_idx] != 0);
            last  = stb && (m_beats + 1 == blen_of(m_burst));
            fin   = (stb && (eot_in || (m_cnt != 0 && m_bytes + 1 == m_cnt) ||
                     (!dir && buf_short[m_idx] && fill[m_idx] == 1))) ||
                    (en && !dir && buf_short[m_idx] && fill[m_idx] == 0);
            clr   = cfg_wr && cfg_addr == 2'd3 && cfg_wdata[0];
            rs    = cfg_wr && cfg_addr == 2'd0;
            if (!en || m_done || fin) m_dreq = 0;
            else if (last)            m_dreq = 0;
            else if (!m_dreq && ready) m_dreq = 1;
            m_beats = (rs || fin) ? 0 : (stb ? (last ? 0 : m_beats + 1) : m_beats);
            m_bytes = (rs || clr) ? 0 : (stb ? m_bytes + 1 : m_bytes);
            if (fin) m_done = 1; else if (clr) m_done = 0;
            if (cfg_wr) begin
                case (cfg_addr)
                    2'd0: begin
                        m_idx = int'(cfg_wdata[3:0]); m_burst = int'(cfg_wdata[5:4]);
                        m_dreq_low = cfg_wdata[6]; m_dack_low = cfg_wdata[7]; m_donly = cfg_wdata[8];
                    end
                    2'd1: m_mask = cfg_wdata;
                    2'd2: m_cnt = int'(cfg_wdata);
                    default: ;
                endcase
            end
        end
        // Endpoint buffer model reacts to the strobes seen at this edge
        if (brd && fill[sel] > 0) begin
            fill[sel]--;
            if (fill[sel] == 0) buf_short[sel] = 1'b0;
        end
        if (bwr && fill[sel] < DEPTH) fill[sel]++;
        check(dreq_pin == (m_dreq ^ m_dreq_low), "R4 dreq_pin", dreq_pin, m_dreq ^ m_dreq_low);
        check(dma_done == m_done, "R9 dma_done", dma_done, m_done);
    endtask

    task automatic wcfg(input logic [1:0] a, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) fill[i] = 0;
        m_idx = 0; m_burst = 0; m_cnt = 0; m_beats = 0; m_bytes = 0; m_mask = '0;
        m_dreq_low = 0; m_dack_low = 0; m_donly = 0; m_dreq = 0; m_done = 0;
        io_ep_sel = 4'd9;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(dreq_pin == 1'b0, "R1 dreq after reset", dreq_pin, 0);
        check(dma_done == 1'b0, "R1 done after reset", dma_done, 0);
        check(buf_sel == 4'd9, "R1 sel after reset", buf_sel, 9);

        // R4: index 1 with data never requests
        fill[1] = 10;
        wcfg(2'd0, 16'h0001);
        repeat (3) tick();
        check(dreq_pin == 1'b0, "R4 index 1 disabled", dreq_pin, 0);

        // R4/R5/R2/R3: IN slot 3, burst code 1 = 4 bytes
        wcfg(2'd1, 16'h0008);
        wcfg(2'd0, 16'h0013);
        tick();
        check(dreq_pin == 1'b1, "R4 raise on free space", dreq_pin, 1);
        dack_pin = 1'b1; wr_stb = 1'b1; io_ep_sel = 4'd7;
        #1;
        check(buf_sel == 4'd3, "R3 dack overrides io select", buf_sel, 3);
        check(buf_wr == 1'b1, "R2 IN write strobe passes", buf_wr, 1);
        repeat (4) tick();
        check(dreq_pin == 1'b0, "R5 drop after 4-byte burst", dreq_pin, 0);
        check(fill[3] == 4, "R2 four bytes written", fill[3], 4);
        dack_pin = 1'b0; wr_stb = 1'b0;
        tick();
        check(dreq_pin == 1'b1, "R5 re-raise when ready", dreq_pin, 1);
        dack_pin = 1'b1; rd_stb = 1'b1;
        #1;
        check(buf_rd == 1'b0, "R2 read ignored on IN slot", buf_rd, 0);
        tick();
        check(fill[3] == 4, "R2 IN slot unchanged by read", fill[3], 4);
        rd_stb = 1'b0;
        tick();
        check(fill[3] == 4, "R11 dack without strobe moves nothing", fill[3], 4);
        dack_pin = 1'b0;

        // R8/R9: OUT slot 5, short packet of 3 under a 16-byte burst
        fill[5] = 3; buf_short[5] = 1'b1;
        wcfg(2'd0, 16'h0035);
        tick();
        check(dreq_pin == 1'b1, "R4 raise on OUT data", dreq_pin, 1);
        dack_pin = 1'b1; rd_stb = 1'b1;
        repeat (3) tick();
        check(dma_done == 1'b1, "R8 short packet ends transfer", dma_done, 1);
        check(fill[5] == 0, "R8 all short bytes read", fill[5], 0);
        dack_pin = 1'b0; rd_stb = 1'b0; fill[5] = 20;
        repeat (3) tick();
        check(dreq_pin == 1'b0, "R9 done holds request off", dreq_pin, 0);
        wcfg(2'd3, 16'h0001);
        tick();
        check(dma_done == 1'b0 && dreq_pin == 1'b1, "R9 clear resumes", dreq_pin, 1);

        // R6: EOT on third strobe
        dack_pin = 1'b1; rd_stb = 1'b1;
        repeat (2) tick();
        eot_in = 1'b1;
        tick();
        eot_in = 1'b0; rd_stb = 1'b0; dack_pin = 1'b0;
        check(fill[5] == 17, "R6 EOT byte completes", fill[5], 17);
        check(dma_done == 1'b1 && dreq_pin == 1'b0, "R6 EOT sets done", dma_done, 1);

        // R7: byte count of 5
        wcfg(2'd2, 16'd5);
        wcfg(2'd3, 16'h0001);
        wcfg(2'd0, 16'h0035);
        tick();
        dack_pin = 1'b1; rd_stb = 1'b1;
        repeat (4) tick();
        check(dma_done == 1'b0, "R7 not done before count", dma_done, 0);
        tick();
        check(dma_done == 1'b1, "R7 done at count", dma_done, 1);
        dack_pin = 1'b0; rd_stb = 1'b0;

        // R8: empty packet
        wcfg(2'd2, 16'd0);
        wcfg(2'd3, 16'h0001);
        check(dma_done == 1'b0, "R9 cleared before empty packet", dma_done, 0);
        fill[5] = 0; buf_short[5] = 1'b1;
        tick();
        check(dma_done == 1'b1, "R8 empty packet sets done", dma_done, 1);

        // R10: active-low request and acknowledge, burst of 1
        buf_short[5] = 1'b0; fill[5] = 20;
        wcfg(2'd3, 16'h0001);
        dack_pin = 1'b1;
        wcfg(2'd0, 16'h00C5);
        tick();
        check(dreq_pin == 1'b0, "R10 active-low request asserted", dreq_pin, 0);
        dack_pin = 1'b0; rd_stb = 1'b1;
        tick();
        check(fill[5] == 19, "R10 low acknowledge accepted", fill[5], 19);
        check(dreq_pin == 1'b1, "R5 single-byte burst drops", dreq_pin, 1);
        rd_stb = 1'b0; dack_pin = 1'b1;
        tick();

        // R11: acknowledge-only mode, burst of 8
        dack_pin = 1'b0;
        wcfg(2'd0, 16'h0125);
        tick();
        dack_pin = 1'b1;
        repeat (8) tick();
        check(fill[5] == 11, "R11 acknowledge alone moves bytes", fill[5], 11);
        check(dreq_pin == 1'b0, "R5 drop after 8-byte burst", dreq_pin, 0);
        dack_pin = 1'b0;
        tick();

        // R2: data pass-through
        buf_rdata = 8'hA5; bus_din = 8'h3C;
        #1;
        check(bus_dout == 8'hA5, "R2 read data path", bus_dout, 8'hA5);
        check(buf_wdata == 8'h3C, "R2 write data path", buf_wdata, 8'h3C);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule